// File: doc/BRIEF.md
# Codec Channel Power and Fault Supervisor

This block decides when each half of a PCM voice channel pair may drive its outputs. It runs from a free-running reference clock and watches five slow or asynchronous inputs: a power-enable level, the transmit and receive frame syncs, and the transmit and receive master clocks. From them it derives two enables. `tx_active_o` gates the transmit PCM data and timeslot strobe drivers; when it is low those drivers float. `rx_active_o` qualifies the receive signaling bit; when it is low that bit is forced low.

A channel is allowed to drive only when power is on, it is not in standby, the start-up hold-off has run out and its master clock is toggling. Standby is reached separately per channel when its frame sync stays low long enough, so a system can run transmit-only or receive-only by withholding one sync. All intervals are counts of reference clock cycles set by parameters; the defaults correspond to a 100 MHz reference (5 µs power-down qualification, 20 µs clock loss, 500 µs hold-off, 30 ms standby).

Top module: `chan_pwr_supervisor`

## Requirements
- R1: Once `pwr_on_i` has been low for PD_CYC consecutive reference cycles, both enables are low from the (PD_CYC+3)-th rising edge after `pwr_on_i` fell, and they stay low while it stays low.
- R2: A low pulse on `pwr_on_i` shorter than PD_CYC cycles is ignored: both enables stay high throughout and after it.
- R3: When `tx_fsync_i` stays low for STBY_CYC cycles, `tx_active_o` goes low on the (STBY_CYC+3)-th edge after its last fall, while `rx_active_o` is unaffected.
- R4: When `rx_fsync_i` stays low for STBY_CYC cycles, `rx_active_o` goes low on the (STBY_CYC+3)-th edge after its last fall, while `tx_active_o` is unaffected.
- R5: Recovery: a channel in standby whose frame sync is seen high, or both channels after `pwr_on_i` returns high, are enabled again on the 4th edge after that input rose, provided no other condition blocks them.
- R6: After `rst_n` is released, both enables stay low through the (HOLD_CYC+2)-th rising edge and may go high on the (HOLD_CYC+3)-th.
- R7: If `tx_mclk_i` shows no transition for LOSS_CYC cycles, `tx_active_o` goes low (receive unaffected); it returns within 4 edges of the next transition.
- R8: If `rx_mclk_i` shows no transition for LOSS_CYC cycles, `rx_active_o` goes low (transmit unaffected); it returns within 4 edges of the next transition.
- R9: While `rst_n` is low both enables are low (1 = channel may drive, 0 = outputs safe).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock that times all intervals |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_on_i | input | 1 | Power enable level; low requests power-down |
| tx_fsync_i | input | 1 | Transmit frame sync, asynchronous |
| rx_fsync_i | input | 1 | Receive frame sync, asynchronous |
| tx_mclk_i | input | 1 | Transmit master clock, sampled as data |
| rx_mclk_i | input | 1 | Receive master clock, sampled as data |
| tx_active_o | output | 1 | High when transmit data and strobe may be driven |
| rx_active_o | output | 1 | High when the receive signaling bit may follow its data |

## Verification
Every input passes two synchronizer flops, one counter register and the output register, so a qualifying fall is seen on the output at edge N+3 for a count of N and a rise at edge 4. The bench drives inputs on falling clock edges and samples the enables one tick before and exactly at the due edge for power-down, standby, recovery and hold-off, so that an off-by-one in any counter shows. Clock-loss cases, where the last master-clock transition floats against the reference, are checked in a window that is safely before and safely after the due edge. A table of steady states then confirms that every cause acts on the right channel only.

// File: rtl/chan_sup_pkg.sv
package chan_sup_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_TX  = 0;
  localparam int unsigned CH_RX  = 1;
  localparam int unsigned SYNC_W = 1 + 2 * NUM_CH;
  localparam int unsigned IDX_PWR = 0;

  function automatic int unsigned fs_idx(input int unsigned ch);
    return 1 + ch;
  endfunction

  function automatic int unsigned mclk_idx(input int unsigned ch);
    return 1 + NUM_CH + ch;
  endfunction
endpackage

// File: rtl/sup_sync_bank.sv
module sup_sync_bank #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sup_idle_timer.sv
module sup_idle_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_lim;
  logic          cnt_en;

  assign at_lim = (cnt_q == CW'(LIMIT));
  assign cnt_en = clear_i || !at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (!at_lim) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = at_lim;
endmodule

// File: rtl/sup_clk_watch.sv
module sup_clk_watch #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_s_i,
  output logic lost_o
);
  logic prev_q;
  logic toggled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= mclk_s_i;
    end
  end

  assign toggled = mclk_s_i ^ prev_q;

  sup_idle_timer #(.LIMIT(LIMIT)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (toggled),
    .expired_o(lost_o)
  );
endmodule

// File: rtl/chan_pwr_supervisor.sv
module chan_pwr_supervisor
  import chan_sup_pkg::*;
#(
  parameter int unsigned PD_CYC   = 500,
  parameter int unsigned LOSS_CYC = 2000,
  parameter int unsigned HOLD_CYC = 50000,
  parameter int unsigned STBY_CYC = 3000000
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic pwr_on_i,
  input  logic tx_fsync_i,
  input  logic rx_fsync_i,
  input  logic tx_mclk_i,
  input  logic rx_mclk_i,
  output logic tx_active_o,
  output logic rx_active_o
);
  logic rst_meta_q;
  logic rst_int_n;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] syn_in;

  assign raw_in[IDX_PWR]          = pwr_on_i;
  assign raw_in[fs_idx(CH_TX)]    = tx_fsync_i;
  assign raw_in[fs_idx(CH_RX)]    = rx_fsync_i;
  assign raw_in[mclk_idx(CH_TX)]  = tx_mclk_i;
  assign raw_in[mclk_idx(CH_RX)]  = rx_mclk_i;

  sup_sync_bank #(.W(SYNC_W)) u_sync (
    .clk  (clk_ref),
    .rst_n(rst_int_n),
    .d_i  (raw_in),
    .q_o  (syn_in)
  );

  logic pwr_down;
  logic hold_done;

  sup_idle_timer #(.LIMIT(PD_CYC)) u_pd (
    .clk      (clk_ref),
    .rst_n    (rst_int_n),
    .clear_i  (syn_in[IDX_PWR]),
    .expired_o(pwr_down)
  );

  sup_idle_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk      (clk_ref),
    .rst_n    (rst_int_n),
    .clear_i  (1'b0),
    .expired_o(hold_done)
  );

  logic [NUM_CH-1:0] stby_vec;
  logic [NUM_CH-1:0] lost_vec;
  logic [NUM_CH-1:0] act_d;
  logic [NUM_CH-1:0] act_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    sup_idle_timer #(.LIMIT(STBY_CYC)) u_stby (
      .clk      (clk_ref),
      .rst_n    (rst_int_n),
      .clear_i  (syn_in[fs_idx(ch)]),
      .expired_o(stby_vec[ch])
    );

    sup_clk_watch #(.LIMIT(LOSS_CYC)) u_cw (
      .clk     (clk_ref),
      .rst_n   (rst_int_n),
      .mclk_s_i(syn_in[mclk_idx(ch)]),
      .lost_o  (lost_vec[ch])
    );

    always_comb begin
      act_d[ch] = !pwr_down && !stby_vec[ch] && hold_done && !lost_vec[ch];
    end

    always_ff @(posedge clk_ref or negedge rst_int_n) begin
      if (!rst_int_n) begin
        act_q[ch] <= 1'b0;
      end else begin
        act_q[ch] <= act_d[ch];
      end
    end
  end

  assign tx_active_o = act_q[CH_TX];
  assign rx_active_o = act_q[CH_RX];
endmodule

// File: rtl/chan_pwr_supervisor_chk.sv
module chan_pwr_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_down,
  input logic       hold_done,
  input logic [1:0] stby,
  input logic [1:0] lost,
  input logic       tx_active,
  input logic       rx_active
);
  a_r1_pd_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!tx_active && !rx_active));

  a_r3_tx_stby_off: assert property (@(posedge clk) disable iff (!rst_n)
    stby[0] |=> !tx_active);

  a_r4_rx_stby_off: assert property (@(posedge clk) disable iff (!rst_n)
    stby[1] |=> !rx_active);

  a_r6_holdoff_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_done |=> (!tx_active && !rx_active));

  a_r7_tx_loss_off: assert property (@(posedge clk) disable iff (!rst_n)
    lost[0] |=> !tx_active);

  a_r8_rx_loss_off: assert property (@(posedge clk) disable iff (!rst_n)
    lost[1] |=> !rx_active);

  a_r5_tx_rise_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> ($past(hold_done) && !$past(pwr_down)));
endmodule

bind chan_pwr_supervisor chan_pwr_supervisor_chk u_chk (
  .clk      (clk_ref),
  .rst_n    (rst_n),
  .pwr_down (pwr_down),
  .hold_done(hold_done),
  .stby     (stby_vec),
  .lost     (lost_vec),
  .tx_active(tx_active_o),
  .rx_active(rx_active_o)
);

// File: tb/chan_pwr_supervisor_bench.sv
module chan_pwr_supervisor_bench;
  localparam int unsigned PD   = 6;
  localparam int unsigned LOSS = 8;
  localparam int unsigned HOLD = 40;
  localparam int unsigned STBY = 60;
  localparam int unsigned FRAME = 20;

  // fields: pwr, tx_gen, rx_gen, tx_mclk, rx_mclk, exp_tx, exp_rx
  localparam logic [6:0] VEC [13] = '{
    7'b1111111, 7'b0111100, 7'b1111111, 7'b1011101, 7'b1111111,
    7'b1101110, 7'b1111111, 7'b1110101, 7'b1111111, 7'b1111010,
    7'b1111111, 7'b1001100, 7'b1111111
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b1;
  logic tx_gen_en = 1'b1, rx_gen_en = 1'b1;
  logic tx_man = 1'b0, rx_man = 1'b0;
  logic tx_gen_fs = 1'b0, rx_gen_fs = 1'b0;
  logic tx_mclk_en = 1'b1, rx_mclk_en = 1'b1;
  logic tx_mclk = 1'b0, rx_mclk = 1'b0;
  int   tdiv = 0, rdiv = 0, fcnt = 0;
  logic tx_act, rx_act;
  int   n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  chan_pwr_supervisor #(
    .PD_CYC(PD), .LOSS_CYC(LOSS), .HOLD_CYC(HOLD), .STBY_CYC(STBY)
  ) u_chan_pwr_supervisor (
    .clk_ref    (clk),
    .rst_n      (rst_n),
    .pwr_on_i   (pwr_on),
    .tx_fsync_i (tx_gen_fs | tx_man),
    .rx_fsync_i (rx_gen_fs | rx_man),
    .tx_mclk_i  (tx_mclk),
    .rx_mclk_i  (rx_mclk),
    .tx_active_o(tx_act),
    .rx_active_o(rx_act)
  );

  always @(negedge clk) begin
    if (tx_mclk_en) begin
      if (tdiv == 2) begin tdiv <= 0; tx_mclk <= ~tx_mclk; end
      else tdiv <= tdiv + 1;
    end
    if (rx_mclk_en) begin
      if (rdiv == 2) begin rdiv <= 0; rx_mclk <= ~rx_mclk; end
      else rdiv <= rdiv + 1;
    end
    fcnt      <= (fcnt == FRAME - 1) ? 0 : fcnt + 1;
    tx_gen_fs <= tx_gen_en && (fcnt == 0);
    rx_gen_fs <= rx_gen_en && (fcnt == 0);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [6:0] v);
    if (!v[6]) return "R1";
    if (!v[5] && !v[4]) return "R3 R4";
    if (!v[5]) return "R3";
    if (!v[4]) return "R4";
    if (!v[3]) return "R7";
    if (!v[2]) return "R8";
    return "R5";
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(5);
    check("R9", "tx in reset", tx_act, 1'b0);
    check("R9", "rx in reset", rx_act, 1'b0);
    rst_n = 1'b1;
    tick(HOLD + 2);
    check("R6", "tx before hold-off end", tx_act, 1'b0);
    check("R6", "rx before hold-off end", rx_act, 1'b0);
    tick(1);
    check("R6", "tx at hold-off end", tx_act, 1'b1);
    check("R6", "rx at hold-off end", rx_act, 1'b1);

    foreach (VEC[i]) begin
      pwr_on     = VEC[i][6];
      tx_gen_en  = VEC[i][5];
      rx_gen_en  = VEC[i][4];
      tx_mclk_en = VEC[i][3];
      rx_mclk_en = VEC[i][2];
      tick(100);
      check(req_of(VEC[i]), "table tx", tx_act, VEC[i][1]);
      check(req_of(VEC[i]), "table rx", rx_act, VEC[i][0]);
    end

    // R1 exact timing and R5 power return
    pwr_on = 1'b0;
    tick(PD + 2);
    check("R1", "tx one edge early", tx_act, 1'b1);
    tick(1);
    check("R1", "tx at due edge", tx_act, 1'b0);
    check("R1", "rx at due edge", rx_act, 1'b0);
    pwr_on = 1'b1;
    tick(3);
    check("R5", "tx before power return edge", tx_act, 1'b0);
    tick(1);
    check("R5", "tx power return", tx_act, 1'b1);
    check("R5", "rx power return", rx_act, 1'b1);

    // R2 short power-down pulse ignored
    pwr_on = 1'b0;
    tick(PD - 1);
    pwr_on = 1'b1;
    check("R2", "tx during short low", tx_act, 1'b1);
    tick(4);
    check("R2", "tx after short low", tx_act, 1'b1);
    check("R2", "rx after short low", rx_act, 1'b1);
    tick(10);

    // R3 exact transmit standby, receive independent
    tx_gen_en = 1'b0;
    tick(2);
    tx_man = 1'b1;
    tick(1);
    tx_man = 1'b0;
    tick(STBY + 2);
    check("R3", "tx one edge early", tx_act, 1'b1);
    tick(1);
    check("R3", "tx at due edge", tx_act, 1'b0);
    check("R3", "rx unaffected", rx_act, 1'b1);
    tx_man = 1'b1;
    tick(1);
    tx_man = 1'b0;
    tick(2);
    check("R5", "tx before sync recovery", tx_act, 1'b0);
    tick(1);
    check("R5", "tx sync recovery", tx_act, 1'b1);
    tx_gen_en = 1'b1;
    tick(10);

    // R4 exact receive standby
    rx_gen_en = 1'b0;
    tick(2);
    rx_man = 1'b1;
    tick(1);
    rx_man = 1'b0;
    tick(STBY + 2);
    check("R4", "rx one edge early", rx_act, 1'b1);
    tick(1);
    check("R4", "rx at due edge", rx_act, 1'b0);
    check("R4", "tx unaffected", tx_act, 1'b1);
    rx_gen_en = 1'b1;
    tick(40);
    check("R5", "rx sync recovery", rx_act, 1'b1);

    // R7 transmit clock loss window
    tx_mclk_en = 1'b0;
    tick(LOSS);
    check("R7", "tx before loss due", tx_act, 1'b1);
    tick(6);
    check("R7", "tx after loss", tx_act, 1'b0);
    check("R7", "rx unaffected", rx_act, 1'b1);
    tx_mclk_en = 1'b1;
    tick(8);
    check("R7", "tx clock return", tx_act, 1'b1);

    // R8 receive clock loss window
    rx_mclk_en = 1'b0;
    tick(LOSS);
    check("R8", "rx before loss due", rx_act, 1'b1);
    tick(6);
    check("R8", "rx after loss", rx_act, 1'b0);
    check("R8", "tx unaffected", tx_act, 1'b1);
    rx_mclk_en = 1'b1;
    tick(8);
    check("R8", "rx clock return", rx_act, 1'b1);

    // R9 reset re-entry
    rst_n = 1'b0;
    tick(2);
    check("R9", "tx reset again", tx_act, 1'b0);
    check("R9", "rx reset again", rx_act, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule